// File: doc/BRIEF.md
# Timed Sample Capture Controller

This block sits between a DSP front end and a downstream packet builder. Software, or a sequencer, loads capture commands through a small register-write bus. Each command asks for a number of samples. It may start the moment it is taken from the queue, or it may wait for an exact instant on a free-running 64-bit time base. While a capture is active, the block raises `run` and takes one sample on every cycle where `strobe` is high. It stamps each sample with the current time and a set of flag bits, and places the word in an internal output FIFO that is drained with a valid/ready handshake.

Commands can be linked. A command marked as linked hands over to the next queued command with no gap between samples. The block detects three error cases, each reported downstream as a single error word:
- a timed start that has already passed;
- a link that finds no follow-on command;
- a sample that arrives while the output FIFO is full.

A follow-on command with a count of zero ends a linked sequence cleanly.

Top module: `timed_capture_ctrl`

## Requirements
- R1: After reset, and in the cycle after `clear` is high, `run` and `out_valid` are low. Commands queued before a clear never start: no sample word appears and `run` stays low even when `strobe` is high.
- R2: A write to offset BASE+0 holds {immediate[31], linked[30], count[29:0]}, a write to BASE+1 holds the seconds word, and a write to BASE+2 holds the ticks word and commits the whole command into a queue of CMD_DEPTH entries. The target time is {seconds, ticks}.
- R3: An immediate command raises `run` the cycle after it is taken. While `run` is high, exactly one sample is captured on each cycle with `strobe` high. `run` falls once the count is used up.
- R4: A timed command keeps `run` low until the time base reaches the target. The first sample word of that burst carries a timestamp equal to the target when `strobe` is high at that instant.
- R5: A timed command whose target is already past produces one error word with flags 0001, and produces no sample words. `run` stays low throughout.
- R6: An output word is {flags[3:0], timestamp[63:0], sample[WIDTH-1:0]}. The flag bits are: bit 3 = first sample of a burst, bit 2 = last sample of a burst, bit 1 = overrun error, bit 0 = late-start or broken-link error. A one-sample burst sets both bit 3 and bit 2. An error word sets exactly one error bit and neither burst bit.
- R7: When a linked command runs out and a follow-on command is queued, capture continues at once. The follow-on's own start mode and time are ignored. With `strobe` held high, the timestamps stay consecutive, and no flags are set at the hand-over.
- R8: When a linked command runs out and no follow-on command is queued, the last sample is sent without the end flag, followed by one error word with flags 0001.
- R9: A zero-count follow-on command ends a linked sequence. The last sample carries the end flag, and no error word is sent.
- R10: A strobe that arrives while the output FIFO holds OUT_DEPTH words causes the following:
  - the sample is dropped;
  - `overrun` pulses for one cycle;
  - `run` falls;
  - an error word with flags 0010 follows the buffered words.
- R11: A command queued while an error word is still waiting for FIFO space does not start until that word has been pushed. Its samples follow the error word.
- R12: While `out_valid` is high and `out_ready` is low, `out_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Synchronous flush of both queues; returns the controller to idle |
| wr_stb | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 32 | Register write data |
| now_time | input | 64 | Free-running time base |
| run | output | 1 | High while a capture is active |
| strobe | input | 1 | Sample-valid strobe from the DSP front end |
| smp_in | input | WIDTH | Sample from the DSP front end |
| out_data | output | 4+64+WIDTH | Head word of the output FIFO |
| out_valid | output | 1 | Output FIFO not empty |
| out_ready | input | 1 | Downstream accepts the head word |
| overrun | output | 1 | One-cycle pulse on a dropped sample |

## Verification
Latency:
- A sample taken at a rising edge is in the output FIFO immediately after that edge, so `out_valid` can rise one cycle after the strobe.
- A timed burst's first word carries exactly the target time, because the controller leaves its waiting state one cycle early.
- Error words follow one cycle after the condition is seen, provided the FIFO has space.

The bench drives its time base, strobe and handshake on the falling edge. Its monitor samples 1 ns after that edge and compares each accepted word, in order, with a queue of expected items. Each expected item holds the flags and either an exact timestamp or the step from the previous word. Port-level checks such as `run` low, held data and the overrun pulse count are made a fixed number of falling edges after the stimulus.

// File: rtl/timed_capture_ctrl.sv
module timed_capture_ctrl #(
  parameter int         WIDTH     = 32,
  parameter int         CMD_DEPTH = 4,
  parameter int         OUT_DEPTH = 4,
  parameter logic [7:0] BASE      = 8'd0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear,
  input  logic                  wr_stb,
  input  logic [7:0]            wr_addr,
  input  logic [31:0]           wr_data,
  input  logic [63:0]           now_time,
  output logic                  run,
  input  logic                  strobe,
  input  logic [WIDTH-1:0]      smp_in,
  output logic [4+64+WIDTH-1:0] out_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic                  overrun
);
  localparam int OW  = 4 + 64 + WIDTH;
  localparam int CW  = 96;
  localparam int CAW = $clog2(CMD_DEPTH);
  localparam int OAW = $clog2(OUT_DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN, S_ERR} state_t;

  // staging registers
  logic [31:0] stg_cmd, stg_sec;
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      stg_cmd <= '0;
      stg_sec <= '0;
    end else if (wr_stb) begin
      if (wr_addr == BASE)         stg_cmd <= wr_data;
      if (wr_addr == BASE + 8'd1)  stg_sec <= wr_data;
    end
  end

  // command queue
  logic [CW-1:0]  cmem [CMD_DEPTH];
  logic [CAW-1:0] cwp, crp;
  logic [CAW:0]   ccnt;
  logic           cq_push, cq_pop, cq_ne, cq_full;
  logic [CW-1:0]  head;
  logic           head_chain;
  logic [29:0]    head_lines;

  function automatic logic [CAW-1:0] cinc(input logic [CAW-1:0] p);
    return (p == CAW'(CMD_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cq_ne      = ccnt != '0;
  assign cq_full    = ccnt == (CAW+1)'(CMD_DEPTH);
  assign cq_push    = wr_stb && (wr_addr == BASE + 8'd2) && !cq_full;
  assign head       = cmem[crp];
  assign head_chain = head[94];
  assign head_lines = head[93:64];

  always_ff @(posedge clk)
    if (cq_push) cmem[cwp] <= {stg_cmd, stg_sec, wr_data};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cwp  <= '0;
      crp  <= '0;
      ccnt <= '0;
    end else begin
      if (cq_push) cwp <= cinc(cwp);
      if (cq_pop)  crp <= cinc(crp);
      ccnt <= ccnt + (CAW+1)'(cq_push) - (CAW+1)'(cq_pop);
    end
  end

  // output FIFO
  logic [OW-1:0]  omem [OUT_DEPTH];
  logic [OAW-1:0] owp, orp;
  logic [OAW:0]   ocnt;
  logic           opush, opop, ofull;
  logic [OW-1:0]  oword;

  function automatic logic [OAW-1:0] oinc(input logic [OAW-1:0] p);
    return (p == OAW'(OUT_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign ofull     = ocnt == (OAW+1)'(OUT_DEPTH);
  assign out_valid = ocnt != '0;
  assign out_data  = omem[orp];
  assign opop      = out_valid && out_ready;

  always_ff @(posedge clk)
    if (opush) omem[owp] <= oword;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      owp  <= '0;
      orp  <= '0;
      ocnt <= '0;
    end else begin
      if (opush) owp <= oinc(owp);
      if (opop)  orp <= oinc(orp);
      ocnt <= ocnt + (OAW+1)'(opush) - (OAW+1)'(opop);
    end
  end

  // capture control
  state_t      st;
  logic [29:0] remain;
  logic        chain_r, first_r, err_ovf, ovf_q;
  logic [63:0] target;
  logic        take, ovf_hit, last, eob, push_err, start_now, late;

  assign run       = st == S_RUN;
  assign ovf_hit   = run && strobe && ofull;
  assign take      = run && strobe && !ofull;
  assign last      = remain == 30'd1;
  assign eob       = last && (!chain_r || (cq_ne && head_lines == '0));
  assign cq_pop    = (st == S_IDLE && cq_ne) || (take && last && chain_r && cq_ne);
  assign push_err  = (st == S_ERR) && !ofull;
  assign opush     = take || push_err;
  assign oword     = take ? {first_r, eob, 2'b00, now_time, smp_in}
                          : {2'b00, err_ovf, !err_ovf, now_time, {WIDTH{1'b0}}};
  assign start_now = ({1'b0, now_time} + 65'd1) == {1'b0, target};
  assign late      = now_time >= target;
  assign overrun   = ovf_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      st      <= S_IDLE;
      remain  <= '0;
      chain_r <= 1'b0;
      first_r <= 1'b0;
      err_ovf <= 1'b0;
      target  <= '0;
      ovf_q   <= 1'b0;
    end else begin
      ovf_q <= ovf_hit;
      case (st)
        S_IDLE:
          if (cq_ne && head_lines != '0) begin
            remain  <= head_lines;
            chain_r <= head_chain;
            target  <= head[63:0];
            first_r <= 1'b1;
            st      <= head[95] ? S_RUN : S_WAIT;
          end
        S_WAIT:
          if (start_now)
            st <= S_RUN;
          else if (late) begin
            err_ovf <= 1'b0;
            st      <= S_ERR;
          end
        S_RUN:
          if (ovf_hit) begin
            err_ovf <= 1'b1;
            st      <= S_ERR;
          end else if (take) begin
            first_r <= 1'b0;
            if (!last)
              remain <= remain - 30'd1;
            else if (!chain_r)
              st <= S_IDLE;
            else if (!cq_ne) begin
              err_ovf <= 1'b0;
              st      <= S_ERR;
            end else if (head_lines == '0)
              st <= S_IDLE;
            else begin
              remain  <= head_lines;
              chain_r <= head_chain;
            end
          end
        S_ERR:
          if (!ofull) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tcc_checker.sv
module tcc_checker #(
  parameter int OW = 100
) (
  input logic          clk,
  input logic          rst,
  input logic          clear,
  input logic          run,
  input logic          overrun,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_data
);
  a_r1_clear_idle: assert property (@(posedge clk) disable iff (rst)
    clear |=> !out_valid && !run);

  a_r12_hold_word: assert property (@(posedge clk) disable iff (rst || clear)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r6_one_error_bit: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones(out_data[OW-3 -: 2]) <= 1);

  a_r6_error_no_burst_flags: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_data[OW-3] || out_data[OW-4]) |-> !out_data[OW-1] && !out_data[OW-2]);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst || clear)
    overrun |=> !overrun);

  a_r10_run_stops: assert property (@(posedge clk) disable iff (rst)
    overrun |-> !run);
endmodule

bind timed_capture_ctrl tcc_checker #(.OW(4 + 64 + WIDTH)) u_tcc_chk (
  .clk(clk), .rst(rst), .clear(clear), .run(run), .overrun(overrun),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/tb_timed_capture_ctrl.sv
`timescale 1ns/1ps
module tb_timed_capture_ctrl;
  localparam int WIDTH = 32;
  localparam int OW    = 4 + 64 + WIDTH;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clear = 1'b0;
  logic          wr_stb = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [63:0]   now_time = 64'd100;
  logic          run, strobe, out_valid, overrun;
  logic          out_ready = 1'b1;
  logic          strb_en = 1'b1;
  logic          strb_alt = 1'b0;
  logic [OW-1:0] out_data;

  always #2 clk = ~clk;

  assign strobe = strb_en && (!strb_alt || now_time[0]);

  timed_capture_ctrl #(.WIDTH(WIDTH)) dut (
    .clk(clk), .rst(rst), .clear(clear), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .now_time(now_time), .run(run), .strobe(strobe),
    .smp_in(now_time[WIDTH-1:0]), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .overrun(overrun)
  );

  always @(negedge clk) now_time <= now_time + 64'd1;

  typedef struct {
    logic [3:0]  flags;
    int          mode;   // 0 any, 1 exact, 2 prev+1, 3 prev+2
    logic [63:0] t;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   m_checks = 0, m_fails = 0;
  int   t_checks = 0, t_fails = 0;
  int   run_cnt = 0, ovf_cnt = 0;
  logic [63:0] last_ts = '0;

  always @(negedge clk) begin
    if (!rst && run)     run_cnt++;
    if (!rst && overrun) ovf_cnt++;
  end

  always @(negedge clk) begin
    #1;
    if (!rst && out_valid && out_ready) begin
      logic [3:0]  fl;
      logic [63:0] ts;
      logic [31:0] sm;
      fl = out_data[OW-1 -: 4];
      ts = out_data[WIDTH +: 64];
      sm = out_data[WIDTH-1:0];
      m_checks++;
      if (exp_q.size() == 0) begin
        m_fails++;
        $display("FAIL unexpected word: got flags=%b ts=%0d, expected none", fl, ts);
      end else begin
        exp_t e;
        logic ok;
        e  = exp_q.pop_front();
        ok = (fl == e.flags);
        case (e.mode)
          1: ok = ok && (ts == e.t);
          2: ok = ok && (ts == last_ts + 64'd1);
          3: ok = ok && (ts == last_ts + 64'd2);
          default: ;
        endcase
        if (fl[1:0] == 2'b00) ok = ok && (sm == ts[31:0]);
        if (!ok) begin
          m_fails++;
          $display("FAIL %s: got flags=%b ts=%0d smp=%0d, expected flags=%b mode=%0d t=%0d prev=%0d",
                   e.req, fl, ts, sm, e.flags, e.mode, e.t, last_ts);
        end
      end
      last_ts = ts;
    end
  end

  task automatic chk(input logic cond, input string req, input longint got, input longint expv);
    t_checks++;
    if (!cond) begin
      t_fails++;
      $display("FAIL %s: got %0d, expected %0d", req, got, expv);
    end
  endtask

  task automatic expect_w(input logic [3:0] fl, input int mode, input logic [63:0] t, input string req);
    exp_t e;
    e.flags = fl; e.mode = mode; e.t = t; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic queue_cmd(input logic imm, input logic lnk, input int n, input logic [63:0] t);
    write_reg(8'd0, {imm, lnk, 30'(n)});
    write_reg(8'd1, t[63:32]);
    write_reg(8'd2, t[31:0]);
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (exp_q.size() != 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  function automatic void report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             m_checks + t_checks, m_fails + t_fails);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: got timeout, expected completion");
    t_fails++;
    t_checks++;
    report();
    $finish;
  end

  initial begin
    int base, ovf_base;
    logic [63:0] tgt;
    logic [OW-1:0] held;
    repeat (4) @(negedge clk);
    chk(!run && !out_valid && !overrun, "R1 reset state", {run, out_valid, overrun}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R3 immediate, three samples
    expect_w(4'b1000, 0, 0, "R3 first");
    expect_w(4'b0000, 2, 0, "R3 mid");
    expect_w(4'b0100, 2, 0, "R3 last");
    queue_cmd(1, 0, 3, 0);
    drain("R3 drain");
    chk(!run, "R3 run low after burst", run, 0);

    // R6 single-sample burst
    expect_w(4'b1100, 0, 0, "R6 single");
    queue_cmd(1, 0, 1, 0);
    drain("R6 drain");

    // R3 sparse strobe
    strb_alt = 1'b1;
    expect_w(4'b1000, 0, 0, "R3 alt first");
    expect_w(4'b0000, 3, 0, "R3 alt mid");
    expect_w(4'b0100, 3, 0, "R3 alt last");
    queue_cmd(1, 0, 3, 0);
    drain("R3 alt drain");
    strb_alt = 1'b0;

    // R4 / R2 timed start on time
    tgt = now_time + 64'd40;
    expect_w(4'b1000, 1, tgt, "R4 timed first");
    expect_w(4'b0100, 2, 0, "R4 timed last");
    queue_cmd(0, 0, 2, tgt);
    repeat (10) @(negedge clk);
    chk(!run, "R4 run low while waiting", run, 0);
    drain("R2 R4 drain");

    // R5 late start
    base = run_cnt;
    tgt = now_time - 64'd5;
    expect_w(4'b0001, 0, 0, "R5 late error");
    queue_cmd(0, 0, 3, tgt);
    drain("R5 drain");
    chk(run_cnt == base, "R5 run never high", run_cnt - base, 0);

    // R7 linked hand-over
    strb_en = 1'b0;
    expect_w(4'b1000, 0, 0, "R7 a1");
    expect_w(4'b0000, 2, 0, "R7 a2");
    expect_w(4'b0000, 2, 0, "R7 a3");
    expect_w(4'b0000, 2, 0, "R7 b1");
    expect_w(4'b0100, 2, 0, "R7 b2");
    queue_cmd(1, 1, 3, 0);
    queue_cmd(0, 0, 2, 0);
    strb_en = 1'b1;
    drain("R7 drain");

    // R8 broken link
    strb_en = 1'b0;
    expect_w(4'b1000, 0, 0, "R8 s1");
    expect_w(4'b0000, 2, 0, "R8 s2 no end flag");
    expect_w(4'b0001, 0, 0, "R8 error word");
    queue_cmd(1, 1, 2, 0);
    strb_en = 1'b1;
    drain("R8 drain");

    // R9 zero-count end of link
    strb_en = 1'b0;
    expect_w(4'b1000, 0, 0, "R9 s1");
    expect_w(4'b0000, 2, 0, "R9 s2");
    expect_w(4'b0100, 2, 0, "R9 s3 end");
    queue_cmd(1, 1, 3, 0);
    queue_cmd(1, 0, 0, 0);
    strb_en = 1'b1;
    drain("R9 drain");

    // R10 / R11 / R12 overrun
    out_ready = 1'b0;
    ovf_base = ovf_cnt;
    expect_w(4'b1000, 0, 0, "R10 s1");
    expect_w(4'b0000, 2, 0, "R10 s2");
    expect_w(4'b0000, 2, 0, "R10 s3");
    expect_w(4'b0000, 2, 0, "R10 s4");
    expect_w(4'b0010, 0, 0, "R10 overrun word");
    expect_w(4'b1000, 0, 0, "R11 next first");
    expect_w(4'b0100, 2, 0, "R11 next last");
    queue_cmd(1, 0, 10, 0);
    repeat (20) @(negedge clk);
    held = out_data;
    repeat (3) @(negedge clk);
    chk(out_data == held && out_valid, "R12 word held", out_data[OW-1 -: 4], held[OW-1 -: 4]);
    chk(!run, "R10 run low after overrun", run, 0);
    chk(ovf_cnt - ovf_base == 1, "R10 one overrun pulse", ovf_cnt - ovf_base, 1);
    queue_cmd(1, 0, 2, 0);
    repeat (10) @(negedge clk);
    chk(!run, "R11 later command waits", run, 0);
    out_ready = 1'b1;
    drain("R10 R11 drain");

    // R1 clear discards queued commands
    strb_en = 1'b0;
    queue_cmd(1, 0, 3, 0);
    queue_cmd(1, 0, 3, 0);
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    chk(!run && !out_valid, "R1 idle after clear", {run, out_valid}, 0);
    base = run_cnt;
    strb_en = 1'b1;
    repeat (20) @(negedge clk);
    chk(run_cnt == base, "R1 no run after clear", run_cnt - base, 0);
    chk(!out_valid, "R1 no words after clear", out_valid, 0);

    report();
    $finish;
  end
endmodule